// File: doc/BRIEF.md
# Vector Unit Status Flag Register

This block holds the 12-bit status word of a vector arithmetic unit. The low six bits show the current condition. Four of them summarise the lane flags of the multiply-accumulate pipeline: zero, sign, underflow and overflow. The other two record invalid-operation and divide-by-zero results from the divide/square-root unit.

The upper six bits are sticky shadows of the low six. Each sticky bit collects every value its current bit has taken. It stays set after the condition goes away, until software writes the register.

The arithmetic summary arrives every cycle as a 4-bit vector and is registered unchanged. The divide/root unit reports a finished operation with a one-cycle done strobe. The strobe carries the operation type and three operand indications: dividend zero, divisor (or root operand) zero, and operand negative. A software write port reloads the sticky half. Every flag change, current or sticky, appears on the output one clock after the input that causes it.

Top module: `vu_status_flags`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears all 12 status bits. The word layout, from bit 11 down to bit 0, is: sticky divide-by-zero, sticky invalid, sticky overflow, sticky underflow, sticky sign, sticky zero, divide-by-zero, invalid, overflow, underflow, sign, zero.
- R2: Every cycle, status[3:0] takes the value mac_sum had in the previous cycle. mac_sum bit 0 is zero, bit 1 is sign, bit 2 is underflow and bit 3 is overflow; each is the OR of that flag over all lanes.
- R3: On a done strobe with dv_op = 2'b00 (divide), the invalid bit (status[4]) becomes 1 exactly when dividend and divisor are both zero. The divide-by-zero bit (status[5]) becomes 1 exactly when the divisor is zero and the dividend is not.
- R4: On a done strobe with dv_op = 2'b01 (square root), the invalid bit takes dv_neg and the divide-by-zero bit is cleared.
- R5: On a done strobe with dv_op = 2'b10 (reciprocal square root), the invalid bit takes dv_neg. The divide-by-zero bit becomes 1 exactly when the root operand (dv_den_zero) is zero and the dividend is not.
- R6: status[5:4] hold their value in any cycle without a done strobe. They also hold on a done strobe with the unused code dv_op = 2'b11.
- R7: Sticky bit 6+k is set in the same cycle as its current bit k. It then stays set while no write occurs, even after bit k returns to 0.
- R8: A write (wr_en high) loads status[11:6] from wr_data[11:6]. wr_data[5:0] is ignored, and the current bits keep following their sources.
- R9: When a write and a set current flag coincide, the sticky bit becomes wr_data bit OR the newly registered current bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mac_sum | input | 4 | Lane-ORed arithmetic flags {overflow, underflow, sign, zero} |
| dv_done | input | 1 | Divide/root operation finished this cycle |
| dv_op | input | 2 | Operation type: 00 divide, 01 square root, 10 reciprocal square root, 11 unused |
| dv_num_zero | input | 1 | Dividend is zero |
| dv_den_zero | input | 1 | Divisor or root operand is zero |
| dv_neg | input | 1 | Root operand is negative |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 12 | Software write data; bits 11:6 are loaded |
| status | output | 12 | Status word |

## Verification
The block has no parameters, so the bench builds it at its one fixed 12-bit layout. A full run covers every value of the operation code, including the unused one. It also reaches every combination of the three operand indications and every 4-bit arithmetic summary. Directed cases cover a square root clearing a standing divide-by-zero, and a write landing in the same cycle as a new flag. A long random stretch then mixes writes, strobes and summaries so that sticky bits are set, held and reloaded in many orders.

// File: rtl/vu_status_flags.sv
module vu_status_flags (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  mac_sum,
  input  logic        dv_done,
  input  logic [1:0]  dv_op,
  input  logic        dv_num_zero,
  input  logic        dv_den_zero,
  input  logic        dv_neg,
  input  logic        wr_en,
  input  logic [11:0] wr_data,
  output logic [11:0] status
);
  localparam logic [1:0] OP_DIV   = 2'b00;
  localparam logic [1:0] OP_SQRT  = 2'b01;
  localparam logic [1:0] OP_RSQRT = 2'b10;

  logic [3:0] arith_q;
  logic       inv_q, dbz_q, inv_n, dbz_n;
  logic [5:0] stk_q, cur_n, stk_n;

  always_comb begin
    inv_n = inv_q;
    dbz_n = dbz_q;
    if (dv_done) begin
      unique case (dv_op)
        OP_DIV: begin
          inv_n = dv_num_zero & dv_den_zero;
          dbz_n = dv_den_zero & ~dv_num_zero;
        end
        OP_SQRT: begin
          inv_n = dv_neg;
          dbz_n = 1'b0;
        end
        OP_RSQRT: begin
          inv_n = dv_neg;
          dbz_n = dv_den_zero & ~dv_num_zero;
        end
        default: ;
      endcase
    end
  end

  assign cur_n = {dbz_n, inv_n, mac_sum};
  assign stk_n = (wr_en ? wr_data[11:6] : stk_q) | cur_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arith_q <= '0;
      inv_q   <= 1'b0;
      dbz_q   <= 1'b0;
      stk_q   <= '0;
    end else begin
      arith_q <= mac_sum;
      inv_q   <= inv_n;
      dbz_q   <= dbz_n;
      stk_q   <= stk_n;
    end
  end

  assign status = {stk_q, dbz_q, inv_q, arith_q};

  p_mac_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> status[3:0] == $past(mac_sum));

  p_div_zero_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dv_done && dv_op == OP_DIV && dv_num_zero && dv_den_zero |=> status[4] && !status[5]);

  p_sqrt_clears_dbz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dv_done && dv_op == OP_SQRT |=> !status[5] && status[4] == $past(dv_neg));

  p_rsqrt_dbz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dv_done && dv_op == OP_RSQRT |=> status[5] == $past(dv_den_zero && !dv_num_zero));

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dv_done || dv_op == 2'b11 |=> $stable(status[5:4]));

  p_sticky_covers_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5:0] & ~status[11:6]) == 6'b0);

  p_sticky_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($past(status[11:6]) & ~status[11:6]) == 6'b0);

  p_write_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> status[11:6] == ($past(wr_data[11:6]) | status[5:0]));
endmodule

// File: tb/vu_status_flags_tb.sv
`timescale 1ns/1ps
module vu_status_flags_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mac_sum = '0;
  logic        dv_done = 1'b0;
  logic [1:0]  dv_op = '0;
  logic        dv_num_zero = 1'b0, dv_den_zero = 1'b0, dv_neg = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_data = '0;
  logic [11:0] status;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int cur_zsuo = 0, cur_inv = 0, cur_dbz = 0, sticky = 0;

  always #4 clk = ~clk;

  vu_status_flags u_dut (
    .clk(clk), .rst_n(rst_n), .mac_sum(mac_sum), .dv_done(dv_done), .dv_op(dv_op),
    .dv_num_zero(dv_num_zero), .dv_den_zero(dv_den_zero), .dv_neg(dv_neg),
    .wr_en(wr_en), .wr_data(wr_data), .status(status)
  );

  function automatic int expected();
    return (sticky << 6) | (cur_dbz << 5) | (cur_inv << 4) | cur_zsuo;
  endfunction

  task automatic step(input string tag);
    int ni, nd, cur6;
    @(posedge clk);
    if (!rst_n) begin
      cur_zsuo = 0; cur_inv = 0; cur_dbz = 0; sticky = 0;
    end else begin
      ni = cur_inv; nd = cur_dbz;
      if (dv_done) begin
        if (dv_op == 2'd0) begin
          ni = (dv_num_zero && dv_den_zero) ? 1 : 0;
          nd = (dv_den_zero && !dv_num_zero) ? 1 : 0;
        end else if (dv_op == 2'd1) begin
          ni = dv_neg ? 1 : 0;
          nd = 0;
        end else if (dv_op == 2'd2) begin
          ni = dv_neg ? 1 : 0;
          nd = (dv_den_zero && !dv_num_zero) ? 1 : 0;
        end
      end
      cur_zsuo = int'(mac_sum); cur_inv = ni; cur_dbz = nd;
      cur6 = (nd << 5) | (ni << 4) | cur_zsuo;
      if (wr_en) sticky = int'(wr_data[11:6]);
      sticky = sticky | cur6;
    end
    @(negedge clk);
    checks++;
    if (int'(status) != expected()) begin
      fails++;
      $display("FAIL %s: status=%03h expected=%03h", tag, status, expected());
    end
  endtask

  task automatic idle();
    dv_done = 1'b0; wr_en = 1'b0;
  endtask

  task automatic div_ev(input logic [1:0] op, input logic nz, input logic dz, input logic ng);
    dv_done = 1'b1; dv_op = op; dv_num_zero = nz; dv_den_zero = dz; dv_neg = ng;
  endtask

  initial begin
    @(negedge clk);
    step("R1 reset");
    step("R1 reset");
    mac_sum = 4'hF; div_ev(2'b00, 1'b0, 1'b1, 1'b0);
    step("R1 reset ignores inputs");
    @(negedge clk);
    rst_n = 1'b1; idle(); mac_sum = 4'h0;
    step("R1 after release");

    mac_sum = 4'h1; step("R2 zero");
    mac_sum = 4'h2; step("R2 sign R7");
    mac_sum = 4'h4; step("R2 underflow R7");
    mac_sum = 4'h8; step("R2 overflow R7");
    mac_sum = 4'h0; step("R7 sticky held");
    step("R7 sticky held");

    wr_en = 1'b1; wr_data = 12'h03F; step("R8 write clears, low bits ignored");
    wr_en = 1'b0; step("R8 after clear");
    wr_en = 1'b1; wr_data = 12'hA80; step("R8 write loads");
    wr_en = 1'b0;

    div_ev(2'b00, 1'b1, 1'b1, 1'b0); step("R3 0/0 invalid");
    div_ev(2'b00, 1'b0, 1'b1, 1'b0); step("R3 x/0 dbz");
    div_ev(2'b00, 1'b1, 1'b0, 1'b0); step("R3 0/x clear");
    div_ev(2'b00, 1'b0, 1'b0, 1'b1); step("R3 x/y clear");
    div_ev(2'b00, 1'b0, 1'b1, 1'b0); step("R3 dbz again");
    idle(); step("R6 hold without strobe");
    div_ev(2'b11, 1'b1, 1'b1, 1'b1); step("R6 unused code ignored");
    div_ev(2'b01, 1'b0, 1'b1, 1'b0); step("R4 sqrt clears dbz");
    div_ev(2'b01, 1'b0, 1'b0, 1'b1); step("R4 sqrt negative");
    div_ev(2'b10, 1'b0, 1'b1, 1'b0); step("R5 rsqrt zero operand");
    div_ev(2'b10, 1'b1, 1'b1, 1'b0); step("R5 rsqrt 0/0 no dbz");
    div_ev(2'b10, 1'b0, 1'b0, 1'b1); step("R5 rsqrt negative");
    idle();

    wr_en = 1'b1; wr_data = 12'h000; mac_sum = 4'h5;
    div_ev(2'b00, 1'b0, 1'b1, 1'b0); step("R9 write with new flags");
    idle(); mac_sum = 4'h0; step("R9 after");

    for (int n = 0; n < 3000; n++) begin
      mac_sum = 4'($urandom);
      dv_done = ($urandom % 3) == 0;
      dv_op = 2'($urandom);
      dv_num_zero = 1'($urandom); dv_den_zero = 1'($urandom); dv_neg = 1'($urandom);
      wr_en = ($urandom % 8) == 0;
      wr_data = 12'($urandom);
      step("R2 R3 R4 R5 R6 R7 R8 R9 random");
    end
    idle();
    step("R7 final");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule